// File: doc/BRIEF.md
# Exception and Status Control Coprocessor

This block is the system control coprocessor of a 32-bit MIPS-I style core. It keeps the machine status word, the exception cause, the exception return address, the faulting-address register and a read-only identification word. The core reads and writes these through a small register-indexed port. Writes to the read-only registers are dropped.

When the pipeline reports an exception, the block does four things in the same clock edge. It pushes the mode/interrupt-enable stack, records the code and the branch-delay flag, saves the restart PC, and latches the faulting address on address errors. The vector the fetch unit should jump to is always present on an output and follows the boot-vector bit of the status word. A return-from-exception request pops the stack. Eight interrupt lines are gated by the status mask and the current enable to form a single interrupt request for the pipeline.

Top module: `ctrl_coproc`

## Requirements
- R1: After reset the status register (index 12) reads 0x0040_0000, which means the boot-vector bit 22 is 1 and every other bit is 0. Cause (13), exception PC (14) and bad address (8) read 0. Index 15 reads the PRID_VALUE parameter.
- R2: Status bits 5:0 hold three pairs of (interrupt enable, user mode), in bits {1,0} current, {3,2} previous and {5,4} old. A user-mode bit of 1 means user mode. An accepted exception sets bits 5:0 to {old bits 3:0, 2'b00} at the next edge.
- R3: A return-from-exception request copies bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged.
- R4: On an exception, cause bits 6:2 take the 5-bit code. If the delay flag is 0, the exception PC register takes the reported PC and cause bit 31 is 0. If the delay flag is 1, the register takes PC minus 4 and cause bit 31 is 1.
- R5: The readable registers are bad address 8, status 12, cause 13, exception PC 14 and ID 15. Any other index reads 0. Only status accepts writes, and only in bits 31:28, 22, 15:8 and 5:0; its other bits read 0. Writes to 8, 13, 14 and 15 leave their contents unchanged.
- R6: Cause bits 15:8 show the live interrupt lines. The interrupt request output is 1 exactly when status bit 0 is 1 and some line is 1 whose mask bit (status bit 8+n for line n) is also 1.
- R7: The bad address register loads the reported faulting address only on exceptions with code 0x04 (load/fetch address error) or 0x05 (store address error). Other codes leave it unchanged.
- R8: The vector output is 0x8000_0080 when status bit 22 is 0 and 0xBFC0_0180 when it is 1.
- R9: cop_usable bit 0 is 1 when status bit 28 is 1 or status bit 1 (current user mode) is 0. cop_usable bits 3:1 equal status bits 31:29. user_mode equals status bit 1.
- R10: When several requests arrive in one cycle, an exception wins over return-from-exception, and return-from-exception wins over a status write. The losing requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Register index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| exc_req | input | 1 | Exception accepted this cycle |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_badaddr | input | 32 | Faulting data or fetch address |
| rfe_req | input | 1 | Return-from-exception request |
| irq_lines | input | 8 | Pending interrupt lines |
| irq_req | output | 1 | Masked and enabled interrupt request |
| vector_addr | output | 32 | Exception vector address |
| user_mode | output | 1 | Current user-mode bit |
| cop_usable | output | 4 | Usability of coprocessors 0 to 3 |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight interrupt lines, and ID value 0x0000_0002. With these values the full 8-bit mask field is reachable, and the ID readback can be told apart from zero. The bench walks a table of pushes, pops and register writes so that the three-level stack passes through nested exceptions and returns. It also drives interrupt line and mask combinations, both boot-vector settings, and simultaneous exception, return and write requests.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned CCP_IDX_W = 5;
  localparam int unsigned CCP_CODE_W = 5;

  localparam logic [CCP_IDX_W-1:0] IDX_BADADDR = 5'd8;
  localparam logic [CCP_IDX_W-1:0] IDX_STATUS  = 5'd12;
  localparam logic [CCP_IDX_W-1:0] IDX_CAUSE   = 5'd13;
  localparam logic [CCP_IDX_W-1:0] IDX_EPC     = 5'd14;
  localparam logic [CCP_IDX_W-1:0] IDX_PRID    = 5'd15;

  localparam int unsigned ST_IE_CUR  = 0;
  localparam int unsigned ST_KU_CUR  = 1;
  localparam int unsigned ST_MASK_LO = 8;
  localparam int unsigned ST_BEV     = 22;
  localparam int unsigned ST_CU_LO   = 28;
  localparam int unsigned CS_BD      = 31;
  localparam int unsigned CS_CODE_LO = 2;

  typedef enum logic [CCP_CODE_W-1:0] {
    EXC_INT     = 5'h00,
    EXC_ADDR_LD = 5'h04,
    EXC_ADDR_ST = 5'h05,
    EXC_BUS_I   = 5'h06,
    EXC_BUS_D   = 5'h07,
    EXC_SYS     = 5'h08,
    EXC_BRK     = 5'h09,
    EXC_RESV    = 5'h0A,
    EXC_COPU    = 5'h0B,
    EXC_OVF     = 5'h0C
  } exc_code_e;
endpackage

// File: rtl/ccp_status_stack.sv
module ccp_status_stack #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = 32'h0040_0000,
  parameter logic [XLEN-1:0] WR_MASK   = 32'hF040_FF3F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_q
);
  logic [XLEN-1:0] status_d;
  logic            status_en;

  always_comb begin
    status_d  = status_q;
    status_en = 1'b0;
    if (push) begin
      status_d[5:0] = {status_q[3:0], 2'b00};
      status_en     = 1'b1;
    end else if (pop) begin
      status_d[3:0] = status_q[5:2];
      status_en     = 1'b1;
    end else if (wr_en) begin
      status_d  = wdata & WR_MASK;
      status_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_VAL;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/ccp_exc_capture.sv
module ccp_exc_capture
  import ccp_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              exc_in_delay,
  input  logic [XLEN-1:0]   exc_badaddr,
  output logic [CODE_W-1:0] code_q,
  output logic              bd_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   bad_q
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] epc_d;
  logic            bad_en;

  always_comb begin
    epc_d  = exc_in_delay ? (exc_pc - INSN_BYTES) : exc_pc;
    bad_en = exc_req && ((exc_code == EXC_ADDR_LD) || (exc_code == EXC_ADDR_ST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
      epc_q  <= '0;
    end else if (exc_req) begin
      code_q <= exc_code;
      bd_q   <= exc_in_delay;
      epc_q  <= epc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q <= '0;
    end else if (bad_en) begin
      bad_q <= exc_badaddr;
    end
  end
endmodule

// File: rtl/ccp_irq_gate.sv
module ccp_irq_gate #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               ie_cur,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] lines,
  output logic               irq_req
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign hit[g] = mask[g] & lines[g];
  end

  assign irq_req = ie_cur & (|hit);
endmodule

// File: rtl/ctrl_coproc.sv
module ctrl_coproc
  import ccp_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     NUM_IRQ    = 8,
  parameter int unsigned     NUM_COP    = 4,
  parameter logic [XLEN-1:0] PRID_VALUE = 32'h0000_0002,
  parameter logic [XLEN-1:0] VEC_RAM    = 32'h8000_0080,
  parameter logic [XLEN-1:0] VEC_ROM    = 32'hBFC0_0180
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [CCP_IDX_W-1:0]  reg_addr,
  input  logic [XLEN-1:0]       reg_wdata,
  output logic [XLEN-1:0]       reg_rdata,
  input  logic                  exc_req,
  input  logic [CCP_CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]       exc_pc,
  input  logic                  exc_in_delay,
  input  logic [XLEN-1:0]       exc_badaddr,
  input  logic                  rfe_req,
  input  logic [NUM_IRQ-1:0]    irq_lines,
  output logic                  irq_req,
  output logic [XLEN-1:0]       vector_addr,
  output logic                  user_mode,
  output logic [NUM_COP-1:0]    cop_usable
);
  localparam logic [XLEN-1:0] ST_RESET = XLEN'(1) << ST_BEV;
  localparam logic [XLEN-1:0] ST_CU_MASK = ((XLEN'(1) << NUM_COP) - XLEN'(1)) << ST_CU_LO;
  localparam logic [XLEN-1:0] ST_IM_MASK = ((XLEN'(1) << NUM_IRQ) - XLEN'(1)) << ST_MASK_LO;
  localparam logic [XLEN-1:0] ST_WR_MASK = ST_CU_MASK | ST_IM_MASK | ST_RESET | XLEN'(6'h3F);

  logic [XLEN-1:0]       status_q;
  logic [XLEN-1:0]       cause_val;
  logic [XLEN-1:0]       epc_q;
  logic [XLEN-1:0]       bad_q;
  logic [CCP_CODE_W-1:0] code_q;
  logic                  bd_q;
  logic                  status_wr;
  logic                  pop_ok;

  assign status_wr = reg_wr_en && (reg_addr == IDX_STATUS);
  assign pop_ok    = rfe_req && !exc_req;

  ccp_status_stack #(
    .XLEN     (XLEN),
    .RESET_VAL(ST_RESET),
    .WR_MASK  (ST_WR_MASK)
  ) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (exc_req),
    .pop     (pop_ok),
    .wr_en   (status_wr),
    .wdata   (reg_wdata),
    .status_q(status_q)
  );

  ccp_exc_capture #(
    .XLEN  (XLEN),
    .CODE_W(CCP_CODE_W)
  ) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .exc_code    (exc_code),
    .exc_pc      (exc_pc),
    .exc_in_delay(exc_in_delay),
    .exc_badaddr (exc_badaddr),
    .code_q      (code_q),
    .bd_q        (bd_q),
    .epc_q       (epc_q),
    .bad_q       (bad_q)
  );

  ccp_irq_gate #(
    .NUM_IRQ(NUM_IRQ)
  ) u_irq (
    .ie_cur (status_q[ST_IE_CUR]),
    .mask   (status_q[ST_MASK_LO +: NUM_IRQ]),
    .lines  (irq_lines),
    .irq_req(irq_req)
  );

  always_comb begin
    cause_val                            = '0;
    cause_val[CS_BD]                     = bd_q;
    cause_val[ST_MASK_LO +: NUM_IRQ]     = irq_lines;
    cause_val[CS_CODE_LO +: CCP_CODE_W]  = code_q;
  end

  always_comb begin
    unique case (reg_addr)
      IDX_BADADDR: reg_rdata = bad_q;
      IDX_STATUS:  reg_rdata = status_q;
      IDX_CAUSE:   reg_rdata = cause_val;
      IDX_EPC:     reg_rdata = epc_q;
      IDX_PRID:    reg_rdata = PRID_VALUE;
      default:     reg_rdata = '0;
    endcase
  end

  assign vector_addr = status_q[ST_BEV] ? VEC_ROM : VEC_RAM;
  assign user_mode   = status_q[ST_KU_CUR];

  for (genvar c = 0; c < NUM_COP; c++) begin : g_cop
    if (c == 0) begin : g_sys
      assign cop_usable[c] = status_q[ST_CU_LO] | ~status_q[ST_KU_CUR];
    end else begin : g_ext
      assign cop_usable[c] = status_q[ST_CU_LO + c];
    end
  end
endmodule

// File: rtl/ctrl_coproc_chk.sv
module ctrl_coproc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_req,
  input logic        exc_in_delay,
  input logic [4:0]  exc_code,
  input logic [31:0] exc_pc,
  input logic        rfe_req,
  input logic        reg_wr_en,
  input logic [4:0]  reg_addr,
  input logic [7:0]  irq_lines,
  input logic        irq_req,
  input logic [31:0] status,
  input logic [31:0] cause,
  input logic [31:0] epc,
  input logic [31:0] badaddr
);
  AST_PUSH_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> status[5:0] == {$past(status[3:0]), 2'b00}); // R2

  AST_POP_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_req && !exc_req) |=> (status[3:0] == $past(status[5:2])) && (status[5:4] == $past(status[5:4]))); // R3

  AST_DELAY_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_in_delay) |=> (epc == $past(exc_pc) - 32'd4) && cause[31]); // R4

  AST_CAUSE_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 5'd13 && !exc_req) |=> $stable(cause[31]) && $stable(cause[6:2])); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_lines & status[15:8]) == 8'h00 || !status[0]) |-> !irq_req); // R6

  AST_BADADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != 5'h04 && exc_code != 5'h05) |=> $stable(badaddr)); // R7
endmodule

bind ctrl_coproc ctrl_coproc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_req     (exc_req),
  .exc_in_delay(exc_in_delay),
  .exc_code    (exc_code),
  .exc_pc      (exc_pc),
  .rfe_req     (rfe_req),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .irq_lines   (irq_lines),
  .irq_req     (irq_req),
  .status      (status_q),
  .cause       (cause_val),
  .epc         (epc_q),
  .badaddr     (bad_q)
);

// File: tb/ctrl_coproc_tb_top.sv
module ctrl_coproc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PRID = 32'h0000_0002;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        exc_req;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc;
  logic        exc_in_delay;
  logic [31:0] exc_badaddr;
  logic        rfe_req;
  logic [7:0]  irq_lines;
  logic        irq_req;
  logic [31:0] vector_addr;
  logic        user_mode;
  logic [3:0]  cop_usable;

  int checks;
  int errors;

  ctrl_coproc #(.PRID_VALUE(PRID)) dut_i (
    .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata,
    .exc_req, .exc_code, .exc_pc, .exc_in_delay, .exc_badaddr,
    .rfe_req, .irq_lines, .irq_req, .vector_addr, .user_mode, .cop_usable
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // op: 0 write, 1 exception, 2 return, 3 read only
  // arg: write index, or {delay, code} for an exception
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  arg;
    logic [31:0] data;
    logic [4:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd0, 8'd12,  32'hFFFF_FFFF, 5'd12, 32'hF040_FF3F, 4'd5},  // R5 write mask
    '{2'd0, 8'd12,  32'h0000_0005, 5'd12, 32'h0000_0005, 4'd5},  // R5
    '{2'd1, 8'h08,  32'h0000_1000, 5'd12, 32'h0000_0014, 4'd2},  // R2 push
    '{2'd3, 8'd0,   32'h0,         5'd13, 32'h0000_0020, 4'd4},  // R4 code
    '{2'd3, 8'd0,   32'h0,         5'd14, 32'h0000_1000, 4'd4},  // R4 epc
    '{2'd2, 8'd0,   32'h0,         5'd12, 32'h0000_0015, 4'd3},  // R3 pop
    '{2'd1, 8'h84,  32'h0000_2008, 5'd14, 32'h0000_2004, 4'd4},  // R4 delay
    '{2'd3, 8'd0,   32'h0,         5'd13, 32'h8000_0010, 4'd4},  // R4 bd bit
    '{2'd3, 8'd0,   32'h0,         5'd8,  32'h0000_2009, 4'd7},  // R7 latch
    '{2'd3, 8'd0,   32'h0,         5'd12, 32'h0000_0014, 4'd2},  // R2
    '{2'd1, 8'h0C,  32'h0000_3000, 5'd8,  32'h0000_2009, 4'd7},  // R7 hold
    '{2'd0, 8'd13,  32'hFFFF_FFFF, 5'd13, 32'h0000_0030, 4'd5},  // R5 cause ro
    '{2'd0, 8'd14,  32'h0000_0000, 5'd14, 32'h0000_3000, 4'd5},  // R5 epc ro
    '{2'd0, 8'd8,   32'h0000_0000, 5'd8,  32'h0000_2009, 4'd5},  // R5 bad ro
    '{2'd0, 8'd15,  32'h0000_0000, 5'd15, 32'h0000_0002, 4'd5},  // R5 id ro
    '{2'd3, 8'd0,   32'h0,         5'd9,  32'h0000_0000, 4'd5},  // R5 unmapped
    '{2'd2, 8'd0,   32'h0,         5'd12, 32'h0000_0014, 4'd3},  // R3 old kept
    '{2'd2, 8'd0,   32'h0,         5'd12, 32'h0000_0015, 4'd3}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr_en = 1'b0; reg_wdata = '0; exc_req = 1'b0; exc_code = '0;
    exc_pc = '0; exc_in_delay = 1'b0; exc_badaddr = '0; rfe_req = 1'b0;
  endtask

  task automatic wr_status(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'd12; reg_wdata = v;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    checks = 0;
    errors = 0;
    idle_inputs();
    reg_addr = '0;
    irq_lines = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    read_reg(5'd12, v); check("R1 status reset", v, 32'h0040_0000);
    read_reg(5'd13, v); check("R1 cause reset", v, 32'h0);
    read_reg(5'd14, v); check("R1 epc reset", v, 32'h0);
    read_reg(5'd8,  v); check("R1 bad reset", v, 32'h0);
    read_reg(5'd15, v); check("R1 id", v, PRID);
    check("R8 rom vector", vector_addr, 32'hBFC0_0180);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      case (STEPS[i].op)
        2'd0: begin
          reg_wr_en = 1'b1; reg_addr = STEPS[i].arg[4:0]; reg_wdata = STEPS[i].data;
        end
        2'd1: begin
          exc_req = 1'b1; exc_code = STEPS[i].arg[4:0]; exc_in_delay = STEPS[i].arg[7];
          exc_pc = STEPS[i].data; exc_badaddr = STEPS[i].data + 32'd1;
        end
        2'd2: rfe_req = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      idle_inputs();
      read_reg(STEPS[i].raddr, v);
      checks++;
      if (v !== STEPS[i].exp) begin
        errors++;
        $display("FAIL table row %0d R%0d actual %08h expected %08h",
                 i, STEPS[i].req, v, STEPS[i].exp);
      end
    end

    // R8: boot-vector bit cleared
    wr_status(32'h0000_0000);
    check("R8 ram vector", vector_addr, 32'h8000_0080);
    check("R9 kernel usable", {28'h0, cop_usable}, 32'h1);

    // R9: user mode, no CU bits, then CU0 and CU2
    wr_status(32'h0000_0002);
    check("R9 user mode flag", {31'h0, user_mode}, 32'h1);
    check("R9 user no cop", {28'h0, cop_usable}, 32'h0);
    wr_status(32'h5000_0002);
    check("R9 cu0 cu2", {28'h0, cop_usable}, 32'h5);

    // R6: mask line 2, enable on
    wr_status(32'h0000_0401);
    irq_lines = 8'h04; #1;
    check("R6 masked line fires", {31'h0, irq_req}, 32'h1);
    irq_lines = 8'h08; #1;
    check("R6 unmasked line quiet", {31'h0, irq_req}, 32'h0);
    read_reg(5'd13, v);
    check("R6 cause shows lines", {24'h0, v[15:8]}, 32'h08);
    wr_status(32'h0000_0400);
    irq_lines = 8'h04; #1;
    check("R6 enable off", {31'h0, irq_req}, 32'h0);
    irq_lines = 8'h00;

    // R10: exception beats return and write
    wr_status(32'h0000_0005);
    @(negedge clk);
    exc_req = 1'b1; exc_code = 5'h08; exc_pc = 32'h4000;
    rfe_req = 1'b1; reg_wr_en = 1'b1; reg_addr = 5'd12; reg_wdata = 32'h0000_FFFF;
    @(negedge clk);
    idle_inputs();
    read_reg(5'd12, v);
    check("R10 exception wins", v, 32'h0000_0014);
    // R10: return beats write
    @(negedge clk);
    rfe_req = 1'b1; reg_wr_en = 1'b1; reg_addr = 5'd12; reg_wdata = 32'h0000_0000;
    @(negedge clk);
    idle_inputs();
    read_reg(5'd12, v);
    check("R10 return wins", v, 32'h0000_0015);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule